// File: doc/BRIEF.md
# Two-Stage SD Card Clock Divider

The block derives two clock-enable streams from its own clock. These are a card clock and a faster companion clock. A single 32-bit control register selects the divide ratio and gates each output. The first stage is a power-of-two pre-divider, and its period strobe forms the high-speed output. The second stage divides that strobe again by 2 or by 4. Its result is the card clock, which the block provides both as a one-cycle strobe and as a 50 % duty level.

Software changes the rate with one register write. That write carries both stop bits and both divider codes together. The block holds the new setting in the register. It moves the setting into the running dividers only when both counters wrap together, so no output ever produces a short pulse. If a write carries a code outside the legal set, the block ignores the divider part of that write and latches an error flag. A status port always shows the total ratio in use.

Top module: `sd_clkdiv`

## Requirements
- R1: The control register reads back as: bit 9 high-speed stop, bit 8 card stop, bits 4:2 pre-divider code, bits 1:0 final code, bit 31 error flag, and zero in all other bits. A legal write is stored and read back unchanged.
- R2: Pre-divider codes 0 to 4 divide by 1, 2, 4, 8 and 16.
- R3: Final code 0 divides by 2 and final code 1 divides by 4. `div_ratio` shows the product of the two stages currently in use, so its legal values are 2, 4, 8, 16, 32 and 64.
- R4: While the card output runs, `card_ce` pulses for one cycle every `div_ratio` cycles. `card_clk` is high for exactly half of each such period, and that half ends in the `card_ce` cycle.
- R5: While the high-speed output runs, `hs_ce` pulses once every pre-divider ratio cycles, which is every cycle for code 0.
- R6: When the pre-divider code is 2 or more, `hs_ce` stays low whatever the high-speed stop bit holds.
- R7: Each stop bit silences only its own output. A stopped card output holds `card_clk` and `card_ce` low. `both_on` is 1 only while both outputs run.
- R8: A write with a pre-divider code of 5 to 7, or a final code of 2 or 3, leaves both divider fields and the ratio unchanged. That write still updates the stop bits and sets bit 31. Bit 31 stays set until a write with bit 31 = 1 clears it.
- R9: A new divider setting takes effect only at the cycle where both counters wrap. The card period in which the write happens completes at the old length, and the next period uses the new length.
- R10: After reset the register reads 0x0000_0301: both outputs stopped, pre-divider code 0, final code 1, `div_ratio` = 4, and all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock; all logic and strobes are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Current register contents |
| card_clk | output | 1 | Card clock level, 50 % duty, low when stopped |
| card_ce | output | 1 | Card clock enable strobe |
| hs_ce | output | 1 | High-speed clock enable strobe |
| div_ratio | output | 7 | Total divide ratio currently applied |
| both_on | output | 1 | Both outputs running |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe with stable data. They also assume that reset is held for several cycles. The bench drives every write as a one-cycle pulse on a rising edge and holds reset for five cycles. The bench measures periods only after waiting at least three maximum-length card periods following a change, so the measured intervals come from a settled divider. There is one exception: the rate-change check deliberately aligns its write to a card strobe, so the switch-over point it checks is known.

// File: rtl/sdcd_pkg.sv
package sdcd_pkg;

  localparam int REG_W         = 32;
  localparam int PRE_CODE_W    = 3;
  localparam int FIN_CODE_W    = 2;
  localparam int PRE_MAX_CODE  = 4;
  localparam int FIN_MAX_CODE  = 1;
  localparam int HS_PRE_LIMIT  = 2;
  localparam int PRE_CNT_W     = PRE_MAX_CODE;
  localparam int PRE_RATIO_W   = PRE_MAX_CODE + 1;
  localparam int FIN_CNT_W     = 2;
  localparam int RATIO_W       = PRE_RATIO_W + 2;

  localparam int ERR_BIT       = 31;
  localparam int HS_STOP_BIT   = 9;
  localparam int CARD_STOP_BIT = 8;
  localparam int PRE_LSB       = 2;
  localparam int FIN_LSB       = 0;

  typedef struct packed {
    logic                  hs_stop;
    logic                  card_stop;
    logic [PRE_CODE_W-1:0] pre;
    logic [FIN_CODE_W-1:0] fin;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{hs_stop: 1'b1, card_stop: 1'b1,
                                     pre: '0, fin: FIN_CODE_W'(1)};

  function automatic logic [PRE_RATIO_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
    pre_ratio = PRE_RATIO_W'(1) << code;
  endfunction

  function automatic logic [FIN_CNT_W:0] fin_ratio(input logic [FIN_CODE_W-1:0] code);
    fin_ratio = (code == FIN_CODE_W'(1)) ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/sdcd_rst_sync.sv
module sdcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdcd_ctrl_reg.sv
module sdcd_ctrl_reg
  import sdcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output div_cfg_t         cfg,
  output logic             err,
  output logic [REG_W-1:0] rdata
);
  div_cfg_t cfg_q, cfg_d, wr_cfg;
  logic     err_q, err_d;
  logic     bad_code;

  always_comb begin
    wr_cfg.hs_stop   = wdata[HS_STOP_BIT];
    wr_cfg.card_stop = wdata[CARD_STOP_BIT];
    wr_cfg.pre       = wdata[PRE_LSB +: PRE_CODE_W];
    wr_cfg.fin       = wdata[FIN_LSB +: FIN_CODE_W];
    bad_code = (int'(wr_cfg.pre) > PRE_MAX_CODE) || (int'(wr_cfg.fin) > FIN_MAX_CODE);
  end

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (wr) begin
      if (wdata[ERR_BIT]) err_d = 1'b0;
      cfg_d.hs_stop   = wr_cfg.hs_stop;
      cfg_d.card_stop = wr_cfg.card_stop;
      if (bad_code) begin
        err_d = 1'b1;
      end else begin
        cfg_d.pre = wr_cfg.pre;
        cfg_d.fin = wr_cfg.fin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata                            = '0;
    rdata[ERR_BIT]                   = err_q;
    rdata[HS_STOP_BIT]               = cfg_q.hs_stop;
    rdata[CARD_STOP_BIT]             = cfg_q.card_stop;
    rdata[PRE_LSB +: PRE_CODE_W]     = cfg_q.pre;
    rdata[FIN_LSB +: FIN_CODE_W]     = cfg_q.fin;
  end

  assign cfg = cfg_q;
  assign err = err_q;

  // R8: a reserved code leaves both divider fields as they were
  p_bad_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bad_code) |=> ($stable(cfg_q.pre) && $stable(cfg_q.fin)));

  // R8: error flag only drops on an explicit clearing write
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr && wdata[ERR_BIT])) |=> err_q);
endmodule

// File: rtl/sdcd_div_core.sv
module sdcd_div_core
  import sdcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  div_cfg_t             cfg,
  output div_cfg_t             act,
  output logic                 pre_tick,
  output logic                 wrap,
  output logic [FIN_CNT_W-1:0] fin_cnt,
  output logic [RATIO_W-1:0]   ratio
);
  logic [PRE_CNT_W-1:0]   pre_cnt_q, pre_cnt_d;
  logic [FIN_CNT_W-1:0]   fin_cnt_q, fin_cnt_d;
  div_cfg_t               act_q, act_d;
  logic [PRE_RATIO_W-1:0] pre_r;
  logic [FIN_CNT_W:0]     fin_r;
  logic                   hs_illegal;

  always_comb begin
    pre_r    = pre_ratio(act_q.pre);
    fin_r    = fin_ratio(act_q.fin);
    pre_tick = ({1'b0, pre_cnt_q} == pre_r - PRE_RATIO_W'(1));
    wrap     = pre_tick && ({1'b0, fin_cnt_q} == fin_r - 3'd1);
    ratio    = (act_q.fin == FIN_CODE_W'(1)) ? (RATIO_W'(pre_r) << 2)
                                             : (RATIO_W'(pre_r) << 1);
  end

  always_comb begin
    hs_illegal = (int'(cfg.pre) >= HS_PRE_LIMIT);
    pre_cnt_d  = pre_cnt_q + PRE_CNT_W'(1);
    fin_cnt_d  = fin_cnt_q;
    act_d      = act_q;
    if (pre_tick) begin
      pre_cnt_d = '0;
      fin_cnt_d = fin_cnt_q + FIN_CNT_W'(1);
    end
    if (wrap) begin
      fin_cnt_d       = '0;
      act_d           = cfg;
      act_d.hs_stop   = cfg.hs_stop | hs_illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      fin_cnt_q <= '0;
      act_q     <= CFG_RESET;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      fin_cnt_q <= fin_cnt_d;
      act_q     <= act_d;
    end
  end

  assign act     = act_q;
  assign fin_cnt = fin_cnt_q;

  // R9: the applied setting moves only on a joint wrap
  p_switch_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));

  // R6: a running high-speed output implies a low pre-divider code
  p_hs_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q.hs_stop |-> (int'(act_q.pre) < HS_PRE_LIMIT));

  // R3: reported ratio is always one of the legal powers of two
  p_ratio_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ratio) == 1) && (ratio >= RATIO_W'(2)) && (ratio <= RATIO_W'(64)));

  // R2: pre-divider counter never passes its terminal value
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pre_cnt_q} < pre_r));
endmodule

// File: rtl/sdcd_out_gate.sv
module sdcd_out_gate
  import sdcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  div_cfg_t             act,
  input  logic                 pre_tick,
  input  logic                 wrap,
  input  logic [FIN_CNT_W-1:0] fin_cnt,
  output logic                 card_clk,
  output logic                 card_ce,
  output logic                 hs_ce,
  output logic                 both_on
);
  logic [FIN_CNT_W:0] half;

  always_comb begin
    half     = fin_ratio(act.fin) >> 1;
    card_ce  = !act.card_stop && wrap;
    card_clk = !act.card_stop && ({1'b0, fin_cnt} >= half);
    hs_ce    = !act.hs_stop && pre_tick;
    both_on  = !act.card_stop && !act.hs_stop;
  end

  // R4: each card strobe closes a high phase of the card level
  p_ce_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_ce |-> card_clk);

  // R4: card level falls only right after a card strobe
  p_fall_after_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk && !card_ce) |=> card_clk);
endmodule

// File: rtl/sd_clkdiv.sv
module sd_clkdiv
  import sdcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               card_clk,
  output logic               card_ce,
  output logic               hs_ce,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               both_on
);
  logic                 rst_n_s;
  div_cfg_t             cfg, act;
  logic                 err;
  logic                 pre_tick, wrap;
  logic [FIN_CNT_W-1:0] fin_cnt;

  sdcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  sdcd_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr(bus_wr), .wdata(bus_wdata),
    .cfg(cfg), .err(err), .rdata(bus_rdata));

  sdcd_div_core u_core (
    .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .act(act), .pre_tick(pre_tick),
    .wrap(wrap), .fin_cnt(fin_cnt), .ratio(div_ratio));

  sdcd_out_gate u_gate (
    .clk(clk), .rst_n(rst_n_s), .act(act), .pre_tick(pre_tick), .wrap(wrap),
    .fin_cnt(fin_cnt), .card_clk(card_clk), .card_ce(card_ce), .hs_ce(hs_ce),
    .both_on(both_on));

  // R8: error bit on the bus mirrors the sticky flag
  p_err_visible_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rdata[ERR_BIT] == err);
endmodule

// File: tb/tb_sd_clkdiv.sv
module tb_sd_clkdiv;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        card_clk, card_ce, hs_ce, both_on;
  logic [6:0]  div_ratio;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  string sb_tag = "R4";
  longint cyc = 0;
  longint last_ce = -1;

  always #4 clk = ~clk;

  sd_clkdiv dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .card_clk(card_clk), .card_ce(card_ce),
    .hs_ce(hs_ce), .div_ratio(div_ratio), .both_on(both_on));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: card strobe intervals against the expected queue
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (card_ce) begin
      if (last_ce >= 0 && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk((cyc - last_ce) == e, sb_tag, cyc - last_ce, e);
      end
      last_ce <= cyc;
    end
  end

  task automatic write_reg(input logic [31:0] v);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_wdata = v;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (200) @(posedge clk);
  endtask

  task automatic push_periods(input int p, input int n, input string tag);
    sb_tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(p);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic window(output int c, output int h, output int hi);
    c = 0; h = 0; hi = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      c  += int'(card_ce);
      h  += int'(hs_ce);
      hi += int'(card_clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, h, hi;
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 / R1: reset state
    chk(bus_rdata == 32'h0000_0301, "R10 rdata", bus_rdata, 32'h301);
    chk(div_ratio == 7'd4, "R10 ratio", div_ratio, 4);
    chk({card_clk, card_ce, hs_ce, both_on} == 4'b0, "R10 outputs", {card_clk, card_ce, hs_ce, both_on}, 0);
    window(c, h, hi);
    chk(c == 0 && h == 0 && hi == 0, "R7 stopped quiet", c + h + hi, 0);

    // R2 R3 R4 R5: pre 0, final /2, both running
    write_reg(32'h0000_0000); settle();
    chk(div_ratio == 7'd2, "R3 ratio 2", div_ratio, 2);
    chk(both_on == 1'b1, "R7 both_on", both_on, 1);
    window(c, h, hi);
    chk(h == 128, "R5 hs every cycle", h, 128);
    chk(hi == 64, "R4 duty ratio 2", hi, 64);
    push_periods(2, 4, "R4 period 2"); drain();

    // pre 1 (/2), final /4
    write_reg(32'h0000_0005); settle();
    chk(div_ratio == 7'd8, "R2 ratio 8", div_ratio, 8);
    window(c, h, hi);
    chk(h == 64, "R5 hs period 2", h, 64);
    chk(hi == 64, "R4 duty ratio 8", hi, 64);
    chk(c == 16, "R4 card count ratio 8", c, 16);
    push_periods(8, 3, "R4 period 8"); drain();

    // R6: pre code 2 with high-speed stop clear
    write_reg(32'h0000_0008); settle();
    @(negedge clk);
    chk(bus_rdata == 32'h0000_0008, "R1 readback", bus_rdata, 8);
    chk(div_ratio == 7'd8, "R2 ratio 4x2", div_ratio, 8);
    window(c, h, hi);
    chk(h == 0, "R6 hs forced off", h, 0);
    chk(both_on == 1'b0, "R6 both_on off", both_on, 0);
    push_periods(8, 2, "R4 period 8b"); drain();

    // maximum ratio 64
    write_reg(32'h0000_0211); settle();
    chk(div_ratio == 7'd64, "R3 ratio 64", div_ratio, 64);
    window(c, h, hi);
    chk(hi == 64 && c == 2, "R4 duty ratio 64", hi * 10 + c, 642);

    // R9: change applied at the end of the current period
    push_periods(64, 1, "R9 pre-change"); drain();
    write_reg(32'h0000_0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(div_ratio == 7'd64, "R9 ratio held", div_ratio, 64);
    push_periods(64, 1, "R9 old period completes");
    push_periods(2, 3, "R9 new period");
    drain();
    @(negedge clk);
    chk(div_ratio == 7'd2, "R9 ratio switched", div_ratio, 2);

    // R7: card stopped, high-speed running
    write_reg(32'h0000_0104); settle();
    chk(div_ratio == 7'd4, "R7 ratio 4", div_ratio, 4);
    window(c, h, hi);
    chk(c == 0 && hi == 0, "R7 card silent", c + hi, 0);
    chk(h == 64, "R7 hs independent", h, 64);
    chk(both_on == 1'b0, "R7 both_on low", both_on, 0);

    // R8: reserved pre code
    write_reg(32'h0000_0014); settle();
    @(negedge clk);
    chk(bus_rdata == 32'h8000_0004, "R8 pre reserved", bus_rdata, 32'h8000_0004);
    chk(div_ratio == 7'd4, "R8 ratio kept", div_ratio, 4);
    push_periods(4, 3, "R8 period kept"); drain();
    // reserved final code
    write_reg(32'h0000_0002); settle();
    @(negedge clk);
    chk(bus_rdata == 32'h8000_0004, "R8 fin reserved", bus_rdata, 32'h8000_0004);
    // legal write without clear keeps flag
    write_reg(32'h0000_0004);
    @(negedge clk);
    chk(bus_rdata[31] == 1'b1, "R8 sticky", bus_rdata[31], 1);
    write_reg(32'h8000_0004);
    @(negedge clk);
    chk(bus_rdata == 32'h0000_0004, "R8 cleared", bus_rdata, 4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule